// File: doc/BRIEF.md
# Cell Monitor Mode Controller

This block is the control core of a twelve-channel battery cell monitor. A three-bit duty field picks the operating mode. At 0 the block is in standby and makes no conversions. At 1 it is powered and converts only when asked. At 2 to 7 it also runs periodic limit scans, and each step up in the field doubles the interval between scans. Each scan walks the active channels in ascending order. For each one it raises a conversion request to an external converter and holds it until that converter returns a 12-bit code.

Each returned code is stored as that cell's result. The code uses an offset encoding: 0x200 means zero volts and one step is 1.5 mV. Because the thresholds use the same encoding, the code is compared directly against a programmable under-voltage threshold and an over-voltage threshold. The result sets or clears that cell's two flag bits. Mask bits and a ten-cell option remove channels from every scan. A clear strobe fills all result registers with 0xFFF, so software can tell whether fresh conversions arrived. A status output reports "all well and not busy", either as a steady level or as a square wave.

Top module: `cellmon_ctrl`

## Requirements
- R1: With the duty field at 0 the block issues no conversion request and ignores start and periodic triggers. A scan in progress is abandoned: conv_req_o is low from the first clock edge that sees the field at 0.
- R2: With the duty field at 1 no periodic scan ever starts. A start strobe that is accepted launches a scan.
- R3: With the duty field m in 2..7, a periodic scan is triggered every BASE_PERIOD·2^(m−2) cycles. The interval counter restarts whenever the field changes. A trigger that arrives while a scan is already running is dropped.
- R4: A start strobe is accepted in modes 1 to 7 unless a scan is already running or the strobe falls in the guard window. The guard window is the last SKIP_WIN cycles of each periodic interval, up to and including the trigger cycle. Within a scan the channels are requested in ascending index order, and conv_req_o and conv_ch_o hold steady until conv_done_i.
- R5: When the code for cell i arrives, the UV flag bit i becomes (code < uv_thr_i) and the OV flag bit i becomes (code > ov_thr_i). Both comparisons are unsigned on the offset code (0x200 = 0 V). Flags update in periodic and explicit scans alike.
- R6: A cell is active when its mask bit is 0 and it is not cell index 10 or 11 while cell10_i is 1. Inactive cells are never requested and their results are not changed. Their flag bits read back as 0.
- R7: Reset and the clear strobe set every result to 0xFFF. When clear_i coincides with an arriving code, the clear wins and that code is not stored.
- R8: busy_o is 1 from the cycle after an accepted start strobe until the cycle after the last active channel's code is stored. Periodic scans never raise it.
- R9: The "ok" condition holds when the mode is not 0, busy_o is 0, and no UV or OV flag bit reads 1. With toggle_sel_i at 0, status_o equals ok. With toggle_sel_i at 1, status_o is ok AND a free-running square wave that changes every TOG_HALF cycles and starts low after reset.
- R10: Cell i's result appears on results_o[12·i+11 : 12·i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Duty field: 0 standby, 1 on-demand, 2..7 periodic |
| toggle_sel_i | input | 1 | 1 selects square-wave status, 0 a static level |
| cell10_i | input | 1 | 1 skips cells with index 10 and 11 |
| mask_i | input | 12 | Per-cell exclusion, 1 = excluded |
| uv_thr_i | input | 12 | Under-voltage threshold code |
| ov_thr_i | input | 12 | Over-voltage threshold code |
| start_i | input | 1 | Decoded start-conversion strobe |
| clear_i | input | 1 | Decoded result-clear strobe |
| conv_done_i | input | 1 | Converter returns a code this cycle |
| conv_code_i | input | 12 | Returned code |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_ch_o | output | 4 | Channel being requested |
| results_o | output | 144 | Twelve packed result codes |
| uv_flag_o | output | 12 | Under-voltage flag per cell |
| ov_flag_o | output | 12 | Over-voltage flag per cell |
| busy_o | output | 1 | Explicit conversion in progress |
| status_o | output | 1 | Level or square-wave status |

## Verification
A corrupted interval counter shows up as a periodic conv_req_o rise that is early or late against the computed interval, within one interval. A bad window compare shows up as a busy_o rise, or a missing one, on the cycle after the probing strobe. A wrong channel register shows up as a skipped or repeated conv_ch_o value at the next request. A flag or result write to the wrong cell shows up on uv_flag_o, ov_flag_o or results_o on the cycle after the code arrives. All of these are caught by comparing every output on every cycle.

// File: rtl/cellmon_pkg.sv
package cellmon_pkg;
    localparam int NCELL  = 12;
    localparam int CODE_W = 12;
    localparam int CH_W   = $clog2(NCELL);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [NCELL-1:0]  cellvec_t;
    typedef logic [CH_W-1:0]   ch_t;

    typedef struct packed {
        logic found;
        ch_t  idx;
    } pick_t;

    typedef struct packed {
        logic running;
        logic explicit;
        ch_t  ch;
    } seq_t;

    // lowest active cell with index >= from
    function automatic pick_t pick_from(cellvec_t act, int from);
        pick_t p;
        p = '0;
        for (int i = NCELL - 1; i >= 0; i--) begin
            if (act[i] && i >= from) begin
                p.found = 1'b1;
                p.idx   = CH_W'(i);
            end
        end
        return p;
    endfunction

    function automatic cellvec_t active_set(cellvec_t mask, logic ten_only);
        cellvec_t v;
        v = ~mask;
        if (ten_only) begin
            v[NCELL-1] = 1'b0;
            v[NCELL-2] = 1'b0;
        end
        return v;
    endfunction
endpackage

// File: rtl/cellmon_timer.sv
module cellmon_timer #(
    parameter int BASE_PERIOD = 64,
    parameter int SKIP_WIN    = 4,
    parameter int TOG_HALF    = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_i,
    output logic       trig_o,
    output logic       win_o,
    output logic       tog_o
);
    localparam int MAX_PER = BASE_PERIOD * 32;
    localparam int CNT_W   = $clog2(MAX_PER + 1);
    localparam int TOG_W   = $clog2(TOG_HALF + 1);

    logic [CNT_W-1:0] cnt, per;
    logic [2:0]       mode_q;
    logic             periodic;
    logic [TOG_W-1:0] tcnt;

    always_comb begin
        periodic = (mode_i >= 3'd2);
        per      = periodic ? (CNT_W'(BASE_PERIOD) << (mode_i - 3'd2))
                            : CNT_W'(BASE_PERIOD);
    end

    assign trig_o = periodic && (mode_i == mode_q) && (cnt == per - 1'b1);
    assign win_o  = periodic &&
                    (({1'b0, cnt} + (CNT_W+1)'(SKIP_WIN)) >= {1'b0, per});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            mode_q <= '0;
        end else begin
            mode_q <= mode_i;
            if (!periodic || mode_i != mode_q || trig_o)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt  <= '0;
            tog_o <= 1'b0;
        end else if (tcnt == TOG_W'(TOG_HALF - 1)) begin
            tcnt  <= '0;
            tog_o <= ~tog_o;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // R3
    period_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        trig_o |=> (cnt == '0));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (periodic && mode_i == mode_q) |-> (cnt < per));
endmodule

// File: rtl/cellmon_seq.sv
module cellmon_seq
    import cellmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_i,
    input  cellvec_t   act_i,
    input  logic       start_i,
    input  logic       trig_i,
    input  logic       win_i,
    input  logic       conv_done_i,
    output logic       running_o,
    output logic       explicit_o,
    output ch_t        ch_o,
    output logic       acc_o
);
    seq_t  st;
    pick_t first_p, next_p;
    logic  awake, start_ok;

    always_comb begin
        awake    = (mode_i != 3'd0);
        start_ok = start_i && awake && !win_i && !st.running;
        first_p  = pick_from(act_i, 0);
        next_p   = pick_from(act_i, int'(st.ch) + 1);
        acc_o    = st.running && conv_done_i && awake;
    end

    always_ff @(posedge clk) begin
        if (rst || !awake) begin
            st <= '0;
        end else if (!st.running) begin
            if ((start_ok || trig_i) && first_p.found)
                st <= '{running: 1'b1, explicit: start_ok, ch: first_p.idx};
        end else if (acc_o) begin
            if (next_p.found)
                st.ch <= next_p.idx;
            else
                st <= '0;
        end
    end

    assign running_o  = st.running;
    assign explicit_o = st.explicit;
    assign ch_o       = st.ch;

    // R1
    standby_abort_chk: assert property (@(posedge clk) disable iff (rst)
        !awake |=> !st.running);

    // R4
    ch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st.running && !conv_done_i && awake) |=> (st.running && $stable(st.ch)));

    // R8
    busy_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st.explicit) |-> $past(start_i));
endmodule

// File: rtl/cellmon_store.sv
module cellmon_store
    import cellmon_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear_i,
    input  logic                    acc_i,
    input  ch_t                     ch_i,
    input  code_t                   code_i,
    input  code_t                   uv_thr_i,
    input  code_t                   ov_thr_i,
    input  cellvec_t                act_i,
    output logic [NCELL*CODE_W-1:0] results_o,
    output cellvec_t                uv_o,
    output cellvec_t                ov_o
);
    code_t    res [NCELL];
    cellvec_t uv_q, ov_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            for (int i = 0; i < NCELL; i++) res[i] <= '1;
        end else if (acc_i) begin
            res[ch_i] <= code_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            uv_q <= '0;
            ov_q <= '0;
        end else if (acc_i) begin
            uv_q[ch_i] <= (code_i < uv_thr_i);
            ov_q[ch_i] <= (code_i > ov_thr_i);
        end
    end

    for (genvar g = 0; g < NCELL; g++) begin : g_pack
        assign results_o[g*CODE_W +: CODE_W] = res[g];
    end

    assign uv_o = uv_q & act_i;
    assign ov_o = ov_q & act_i;

    // R7
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (&results_o));

    // R5
    uv_set_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_i && code_i < uv_thr_i) |=> uv_q[$past(ch_i)]);

    // R5
    ov_set_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_i && code_i > ov_thr_i) |=> ov_q[$past(ch_i)]);
endmodule

// File: rtl/cellmon_ctrl.sv
module cellmon_ctrl
    import cellmon_pkg::*;
#(
    parameter int BASE_PERIOD = 64,
    parameter int SKIP_WIN    = 4,
    parameter int TOG_HALF    = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              mode_i,
    input  logic                    toggle_sel_i,
    input  logic                    cell10_i,
    input  logic [NCELL-1:0]        mask_i,
    input  logic [CODE_W-1:0]       uv_thr_i,
    input  logic [CODE_W-1:0]       ov_thr_i,
    input  logic                    start_i,
    input  logic                    clear_i,
    input  logic                    conv_done_i,
    input  logic [CODE_W-1:0]       conv_code_i,
    output logic                    conv_req_o,
    output logic [CH_W-1:0]         conv_ch_o,
    output logic [NCELL*CODE_W-1:0] results_o,
    output logic [NCELL-1:0]        uv_flag_o,
    output logic [NCELL-1:0]        ov_flag_o,
    output logic                    busy_o,
    output logic                    status_o
);
    cellvec_t act;
    logic     trig, win, tog, running, explicit, acc, ok;
    ch_t      ch;

    assign act = active_set(mask_i, cell10_i);

    cellmon_timer #(
        .BASE_PERIOD(BASE_PERIOD),
        .SKIP_WIN   (SKIP_WIN),
        .TOG_HALF   (TOG_HALF)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .mode_i(mode_i),
        .trig_o(trig),
        .win_o (win),
        .tog_o (tog)
    );

    cellmon_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode_i),
        .act_i      (act),
        .start_i    (start_i),
        .trig_i     (trig),
        .win_i      (win),
        .conv_done_i(conv_done_i),
        .running_o  (running),
        .explicit_o (explicit),
        .ch_o       (ch),
        .acc_o      (acc)
    );

    cellmon_store u_store (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (clear_i),
        .acc_i    (acc),
        .ch_i     (ch),
        .code_i   (conv_code_i),
        .uv_thr_i (uv_thr_i),
        .ov_thr_i (ov_thr_i),
        .act_i    (act),
        .results_o(results_o),
        .uv_o     (uv_flag_o),
        .ov_o     (ov_flag_o)
    );

    assign conv_req_o = running;
    assign conv_ch_o  = ch;
    assign busy_o     = running && explicit;

    always_comb begin
        ok       = (mode_i != 3'd0) && !busy_o && !(|uv_flag_o) && !(|ov_flag_o);
        status_o = toggle_sel_i ? (ok && tog) : ok;
    end

    // R8
    busy_req_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> conv_req_o);

    // R9
    status_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !status_o);
endmodule

// File: tb/cellmon_ctrl_tb.sv
module cellmon_ctrl_tb;
    localparam int BASE = 64;
    localparam int WIN  = 4;
    localparam int HALF = 8;
    localparam int LAT  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] mode_i = 3'd0;
    logic toggle_sel_i = 1'b0, cell10_i = 1'b0;
    logic [11:0] mask_i = '0;
    logic [11:0] uv_thr_i = 12'h600, ov_thr_i = 12'hA00;
    logic start_i = 1'b0, clear_i = 1'b0;
    logic conv_done_i = 1'b0;
    logic [11:0] conv_code_i = '0;
    logic conv_req_o, busy_o, status_o;
    logic [3:0] conv_ch_o;
    logic [143:0] results_o;
    logic [11:0] uv_flag_o, ov_flag_o;

    always #4 clk = ~clk;

    cellmon_ctrl #(.BASE_PERIOD(BASE), .SKIP_WIN(WIN), .TOG_HALF(HALF)) u_dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .toggle_sel_i(toggle_sel_i),
        .cell10_i(cell10_i), .mask_i(mask_i), .uv_thr_i(uv_thr_i), .ov_thr_i(ov_thr_i),
        .start_i(start_i), .clear_i(clear_i), .conv_done_i(conv_done_i),
        .conv_code_i(conv_code_i), .conv_req_o(conv_req_o), .conv_ch_o(conv_ch_o),
        .results_o(results_o), .uv_flag_o(uv_flag_o), .ov_flag_o(ov_flag_o),
        .busy_o(busy_o), .status_o(status_o)
    );

    int compared = 0, mismatched = 0;
    int codes [12];

    // behavioural reference state
    int m_cnt, m_mq, m_ch, m_tc;
    bit m_run, m_expl, m_tog;
    bit [11:0] m_uv, m_ov;
    int m_res [12];

    function automatic bit [11:0] f_act();
        bit [11:0] a = ~mask_i;
        if (cell10_i) begin a[10] = 0; a[11] = 0; end
        return a;
    endfunction

    function automatic int f_lowest(bit [11:0] a, int from);
        for (int i = from; i < 12; i++) if (a[i]) return i;
        return -1;
    endfunction

    function automatic int f_per(int m);
        return (m >= 2) ? (BASE << (m - 2)) : BASE;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_mq = 0; m_ch = 0; m_tc = 0;
            m_run = 0; m_expl = 0; m_tog = 0; m_uv = 0; m_ov = 0;
            for (int i = 0; i < 12; i++) m_res[i] = 12'hFFF;
        end else begin
            bit [11:0] a;
            int m, per, nx;
            bit periodic, trig, win, awake, acc, st_ok;
            a = f_act();
            m = int'(mode_i);
            per = f_per(m);
            periodic = (m >= 2);
            trig = periodic && m == m_mq && m_cnt == per - 1;
            win = periodic && (m_cnt + WIN >= per);
            awake = (m != 0);
            acc = m_run && conv_done_i && awake;
            st_ok = start_i && awake && !win && !m_run;
            if (acc) begin
                m_uv[m_ch] = (int'(conv_code_i) < int'(uv_thr_i));
                m_ov[m_ch] = (int'(conv_code_i) > int'(ov_thr_i));
            end
            if (clear_i) for (int i = 0; i < 12; i++) m_res[i] = 12'hFFF;
            else if (acc) m_res[m_ch] = int'(conv_code_i);
            if (!awake) begin
                m_run = 0; m_expl = 0; m_ch = 0;
            end else if (!m_run) begin
                nx = f_lowest(a, 0);
                if ((st_ok || trig) && nx >= 0) begin
                    m_run = 1; m_expl = st_ok; m_ch = nx;
                end
            end else if (acc) begin
                nx = f_lowest(a, m_ch + 1);
                if (nx >= 0) m_ch = nx;
                else begin m_run = 0; m_expl = 0; m_ch = 0; end
            end
            if (!periodic || m != m_mq || trig) m_cnt = 0; else m_cnt++;
            m_mq = m;
            if (m_tc == HALF - 1) begin m_tc = 0; m_tog = !m_tog; end
            else m_tc++;
        end
    end

    task automatic check(string tag, logic [143:0] act, logic [143:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            bit [11:0] a;
            bit ok;
            logic [143:0] er;
            a = f_act();
            for (int i = 0; i < 12; i++) er[i*12 +: 12] = 12'(m_res[i]);
            ok = (mode_i != 0) && !(m_run && m_expl) && ((m_uv & a) == 0) && ((m_ov & a) == 0);
            check("R1 R2 R3 R4 conv_req_o", 144'(conv_req_o), 144'(m_run));
            if (m_run) check("R4 R6 conv_ch_o", 144'(conv_ch_o), 144'(m_ch));
            check("R8 busy_o", 144'(busy_o), 144'(m_run && m_expl));
            check("R5 R6 uv_flag_o", 144'(uv_flag_o), 144'(m_uv & a));
            check("R5 R6 ov_flag_o", 144'(ov_flag_o), 144'(m_ov & a));
            check("R7 R10 results_o", results_o, er);
            check("R9 status_o", 144'(status_o), 144'(toggle_sel_i ? (ok && m_tog) : ok));
        end
    end

    // converter stand-in
    int lat = 0;
    always @(posedge clk) begin
        #2;
        if (conv_done_i) begin
            conv_done_i = 0; lat = 0;
        end else if (conv_req_o) begin
            if (lat == LAT) begin
                conv_done_i = 1; conv_code_i = 12'(codes[conv_ch_o]); lat = 0;
            end else lat++;
        end else lat = 0;
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic pulse_start();
        start_i = 1; tick(); start_i = 0;
    endtask

    task automatic wait_idle();
        tick();
        while (conv_req_o) tick();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL R4 watchdog: actual hung, expected scan completion");
        finish_run();
    end

    initial begin
        // mixed codes: edge cases at and around both thresholds
        codes = '{12'h300, 12'h500, 12'hB00, 12'h200, 12'h600, 12'hA00,
                  12'hA01, 12'h800, 12'h800, 12'h5FF, 12'h800, 12'hFFE};
        tick(5);
        rst = 0;
        tick(3);                                   // R7 R10 reset values, R1 standby
        mode_i = 3'd1; tick(5);
        pulse_start(); wait_idle();                // R2 R4 R5 R8 explicit scan
        tick(40);                                  // R2 no periodic scan
        codes = '{default: 12'h800};
        mask_i = 12'h021; cell10_i = 1;
        pulse_start(); wait_idle();                // R6 masked and top-two skipped
        tick(3);
        clear_i = 1; tick(); clear_i = 0; tick(3); // R7 clear
        mask_i = 0; cell10_i = 0;
        pulse_start(); wait_idle();                // all within limits
        toggle_sel_i = 1; tick(40);                // R9 square wave
        codes = '{12'h300, 12'h500, 12'hB00, 12'h200, 12'h600, 12'hA00,
                  12'hA01, 12'h800, 12'h800, 12'h5FF, 12'h800, 12'hFFE};
        mode_i = 3'd2; tick(250);                  // R3 periodic scans
        while (m_run || m_cnt != BASE - 2) tick();
        pulse_start(); tick(20);                   // R4 start in guard window ignored
        while (m_run || m_cnt < WIN || m_cnt > BASE - WIN - 2) tick();
        pulse_start(); wait_idle();                // R4 R8 start accepted in mode 2
        toggle_sel_i = 0;
        mode_i = 3'd3; tick(300);                  // R3 doubled interval
        mode_i = 3'd7; tick(100);
        mode_i = 3'd1; wait_idle();
        pulse_start(); tick(6);
        mode_i = 3'd0; tick(10);                   // R1 abort
        pulse_start(); tick(5);                    // R1 start ignored
        mode_i = 3'd1; tick(2);
        codes = '{default: 12'h700};
        pulse_start();
        while (!conv_done_i) tick();
        clear_i = 1; tick(); clear_i = 0;          // R7 clear beats store
        wait_idle(); tick(5);
        finish_run();
    end
endmodule